// File: doc/BRIEF.md
# Layer-Filtered User Data FIFO

This block buffers the user-data bytes that an upstream parser pulls out of a video elementary stream. Each byte arrives with a valid strobe and a 2-bit tag that names the syntax layer the byte was found in. A mode bit lets the host store bytes from the group-of-pictures layer only, which is where caption-style data usually sits. Bytes from other layers are then discarded before they reach the storage.

The host drains the buffer through a read strobe and a registered read-data port. It watches empty, full and a sticky overflow flag. One control write carries two bits. One bit sets the layer-filter mode. The other bit is a flush request that is not stored: in a single clock edge it empties the buffer and clears the overflow flag.

Top module: `ulf_top`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `overflow` is 0, `gop_only` is 0 and `rd_data` is 0x00.
- R2: Bytes come out in the order they were stored. `rd_data` takes the next byte on the clock edge that samples `rd_en` while the buffer is not empty.
- R3: A control write with `ctrl_wdata[0]`=1 empties the buffer and clears `overflow` at that edge. Bytes that were not read are lost. The bit is not held, so a later control write with `ctrl_wdata[0]`=0 does not flush.
- R4: A flush in the same cycle as an input byte or a read strobe wins. The byte is not stored, the read pointer does not move, and `rd_data` keeps its value.
- R5: Layer tag encoding: 2'b00 sequence, 2'b01 group of pictures, 2'b10 picture, 2'b11 slice. While `gop_only` is 1, only bytes tagged 2'b01 are stored and the others are discarded.
- R6: While `gop_only` is 0, bytes with any of the four tags are stored. A control write loads `gop_only` from `ctrl_wdata[1]`, and the new mode applies to bytes that arrive in later cycles.
- R7: The buffer holds DEPTH (64) bytes. `full` is 1 exactly when 64 bytes are held, and `empty` is 1 exactly when none are held.
- R8: A byte that passes the filter while `full` is 1 is dropped and sets `overflow`. The flag stays set until a flush. A byte that the filter discards does not set it.
- R9: A read strobe while `empty` is 1 leaves `rd_data` unchanged and does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming user-data byte is valid |
| in_byte | input | 8 | Incoming byte |
| in_layer | input | 2 | Layer tag of the incoming byte |
| ctrl_wr | input | 1 | Host control write strobe |
| ctrl_wdata | input | 2 | Bit 0 flush request, bit 1 group-of-pictures-only mode |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Registered read data |
| empty | output | 1 | No bytes held |
| full | output | 1 | DEPTH bytes held |
| overflow | output | 1 | Sticky: an accepted byte was dropped while full |
| gop_only | output | 1 | Current filter mode |

## Verification
The filter is swept over all four layer tags in both modes, using a distinct byte value for each tag. A stored byte that should have been discarded, or a discarded byte that should have been stored, therefore shows up as a wrong value at the read port. The buffer is filled to the brim and then offered more bytes of every tag, which separates drops caused by the filter from drops caused by a full buffer in the overflow flag. Flushes are placed on top of concurrent writes and reads, and on top of pending data, so that flush priority and the loss of unread bytes can be seen at the read port. Reads on an empty buffer, and reads at the same time as writes, check that the pointers do not move when they should not.

// File: rtl/ulf_pkg.sv
package ulf_pkg;

    typedef enum logic [1:0] {
        LYR_SEQ   = 2'b00,
        LYR_GOP   = 2'b01,
        LYR_PIC   = 2'b10,
        LYR_SLICE = 2'b11
    } layer_e;

    localparam int CTRL_FLUSH_BIT = 0;
    localparam int CTRL_MODE_BIT  = 1;

endpackage

// File: rtl/ulf_admit.sv
module ulf_admit
    import ulf_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] layer_i,
    input  logic       gop_only_i,
    output logic       accept_o
);

    logic layer_ok;

    always_comb begin
        layer_ok = !gop_only_i || (layer_e'(layer_i) == LYR_GOP);
        accept_o = valid_i && layer_ok;
    end

endmodule

// File: rtl/ulf_ctrl.sv
module ulf_ctrl
    import ulf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept_i,
    input  logic                     rd_en_i,
    input  logic                     ctrl_wr_i,
    input  logic [1:0]               ctrl_wdata_i,
    output logic                     wr_fire_o,
    output logic                     rd_fire_o,
    output logic [$clog2(DEPTH)-1:0] waddr_o,
    output logic [$clog2(DEPTH)-1:0] raddr_o,
    output logic                     empty_o,
    output logic                     full_o,
    output logic                     overflow_o,
    output logic                     gop_only_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic          ovf;
        logic          gop;
    } st_t;

    st_t st_d, st_q;
    logic flush;
    logic is_empty, is_full;

    always_comb begin
        st_d      = st_q;
        flush     = ctrl_wr_i && ctrl_wdata_i[CTRL_FLUSH_BIT];
        is_empty  = (st_q.wp == st_q.rp);
        is_full   = (st_q.wp[AW] != st_q.rp[AW]) &&
                    (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
        wr_fire_o = accept_i && !is_full && !flush;
        rd_fire_o = rd_en_i && !is_empty && !flush;

        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.ovf = 1'b0;
        end else begin
            if (wr_fire_o) st_d.wp = st_q.wp + PW'(1);
            if (rd_fire_o) st_d.rp = st_q.rp + PW'(1);
            if (accept_i && is_full) st_d.ovf = 1'b1;
        end

        if (ctrl_wr_i) st_d.gop = ctrl_wdata_i[CTRL_MODE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr_o    = st_q.wp[AW-1:0];
    assign raddr_o    = st_q.rp[AW-1:0];
    assign empty_o    = is_empty;
    assign full_o     = is_full;
    assign overflow_o = st_q.ovf;
    assign gop_only_o = st_q.gop;

    // R3: a flush leaves the buffer empty with overflow cleared
    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[CTRL_FLUSH_BIT]) |=> (empty_o && !overflow_o));

    // R8: an accepted byte against a full buffer raises overflow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && full_o && !flush) |=> overflow_o);

    // R7: a lone write leaves the buffer non-empty
    p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !full_o && !rd_en_i && !ctrl_wr_i) |=> !empty_o);

    // R8: overflow is sticky without a flush
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !ctrl_wr_i) |=> overflow_o);

endmodule

// File: rtl/ulf_store.sv
module ulf_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic                     rd_fire_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [DW-1:0]            rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (wr_fire_i) mem_q[waddr_i] <= wdata_i;
    end

    always_comb begin
        rdata_d = rd_fire_i ? mem_q[raddr_i] : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    // R9: no read fire, no change on the read port
    p_hold_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire_i |=> $stable(rdata_o));

endmodule

// File: rtl/ulf_top.sv
module ulf_top
    import ulf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic [1:0]    in_layer,
    input  logic          ctrl_wr,
    input  logic [1:0]    ctrl_wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          overflow,
    output logic          gop_only
);

    localparam int AW = $clog2(DEPTH);

    logic          accept;
    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr;

    ulf_admit u_admit (
        .valid_i   (in_valid),
        .layer_i   (in_layer),
        .gop_only_i(gop_only),
        .accept_o  (accept)
    );

    ulf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .rd_en_i     (rd_en),
        .ctrl_wr_i   (ctrl_wr),
        .ctrl_wdata_i(ctrl_wdata),
        .wr_fire_o   (wr_fire),
        .rd_fire_o   (rd_fire),
        .waddr_o     (waddr),
        .raddr_o     (raddr),
        .empty_o     (empty),
        .full_o      (full),
        .overflow_o  (overflow),
        .gop_only_o  (gop_only)
    );

    ulf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire_i(wr_fire),
        .waddr_i  (waddr),
        .wdata_i  (in_byte),
        .rd_fire_i(rd_fire),
        .raddr_i  (raddr),
        .rdata_o  (rd_data)
    );

    // R5: in filter mode a non-GOP byte changes no flag
    p_filter_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gop_only && in_valid && in_layer != 2'b01 && !rd_en && !ctrl_wr)
        |=> ($stable(empty) && $stable(full) && $stable(overflow)));

    // R9: read strobe on an empty buffer keeps the read data
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rd_data));

    // R7: the two fill flags never both hold
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

endmodule

// File: tb/ulf_top_tb.sv
`timescale 1ns/1ps
module ulf_top_tb;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic [1:0] in_layer = '0;
    logic       ctrl_wr = 1'b0;
    logic [1:0] ctrl_wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty, full, overflow, gop_only;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mq[$];
    logic [7:0] m_rd = 8'h00;
    logic       m_ovf = 1'b0;
    logic       m_gop = 1'b0;

    always #2 clk = ~clk;

    ulf_top #(.DEPTH(DEPTH), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_layer(in_layer), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .overflow(overflow), .gop_only(gop_only)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "empty", {7'd0, empty}, {7'd0, mq.size() == 0});
        chk(req, "full", {7'd0, full}, {7'd0, mq.size() == DEPTH});
        chk(req, "overflow", {7'd0, overflow}, {7'd0, m_ovf});
        chk(req, "gop_only", {7'd0, gop_only}, {7'd0, m_gop});
        chk(req, "rd_data", rd_data, m_rd);
    endtask

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic step(input logic v, input logic [7:0] b, input logic [1:0] l,
                        input logic rd, input logic cw, input logic [1:0] cwd,
                        input string req);
        int  pre;
        logic acc;
        in_valid = v; in_byte = b; in_layer = l;
        rd_en = rd; ctrl_wr = cw; ctrl_wdata = cwd;
        pre = mq.size();
        acc = v && (!m_gop || l == 2'b01);
        if (cw && cwd[0]) begin
            mq.delete();
            m_ovf = 1'b0;
        end else begin
            if (rd && pre > 0) m_rd = mq.pop_front();
            if (acc && pre < DEPTH) mq.push_back(b);
            if (acc && pre == DEPTH) m_ovf = 1'b1;
        end
        if (cw) m_gop = cwd[1];
        @(negedge clk);
        in_valid = 1'b0; rd_en = 1'b0; ctrl_wr = 1'b0;
        check_all(req);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R6: all tags stored when mode is clear; R2 order
        for (int rep = 0; rep < 3; rep++)
            for (int l = 0; l < 4; l++)
                step(1, 8'(16 * l + rep), 2'(l), 0, 0, 2'b00, "R6");
        while (mq.size() > 0) step(0, 0, 0, 1, 0, 2'b00, "R2");

        // R5: mode set, only tag 01 stored
        step(0, 0, 0, 0, 1, 2'b10, "R5");
        for (int rep = 0; rep < 4; rep++)
            for (int l = 0; l < 4; l++)
                step(1, 8'(8'h80 + 16 * l + rep), 2'(l), 0, 0, 2'b00, "R5");
        while (mq.size() > 0) step(0, 0, 0, 1, 0, 2'b00, "R5");

        // R9: reads on empty hold data, then next byte read first
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 2'b10, "R9");
        step(1, 8'h5A, 2'b01, 0, 0, 2'b00, "R9");
        step(0, 0, 0, 1, 0, 2'b00, "R9");

        // R7/R8: fill in filter mode, then overflow attempts with every tag
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 1), 2'b01, 0, 0, 2'b00, "R7");
        for (int l = 0; l < 4; l++) if (l != 1) step(1, 8'hEE, 2'(l), 0, 0, 2'b00, "R8");
        step(1, 8'hEF, 2'b01, 0, 0, 2'b00, "R8");
        step(0, 0, 0, 1, 0, 2'b00, "R8");
        step(1, 8'hF0, 2'b01, 1, 0, 2'b00, "R2");
        step(0, 0, 0, 0, 1, 2'b00, "R3");   // bit0=0: no flush, mode cleared
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 2'b00, "R2");

        // R3: flush drops pending data and clears overflow
        step(0, 0, 0, 0, 1, 2'b01, "R3");
        step(1, 8'h33, 2'b10, 0, 0, 2'b00, "R3");
        step(0, 0, 0, 1, 0, 2'b00, "R3");

        // R4: flush with a concurrent write and read
        step(1, 8'h41, 2'b00, 0, 0, 2'b00, "R4");
        step(1, 8'h42, 2'b11, 0, 0, 2'b00, "R4");
        step(1, 8'h43, 2'b01, 1, 1, 2'b01, "R4");
        step(0, 0, 0, 1, 0, 2'b00, "R4");
        step(1, 8'h44, 2'b10, 0, 0, 2'b00, "R4");
        step(0, 0, 0, 1, 0, 2'b00, "R4");

        // R2: simultaneous read and write over a wrap
        for (int i = 0; i < 3 * DEPTH; i++)
            step(1, 8'(i * 7), 2'(i), (i % 3) != 0, 0, 2'b00, "R2");
        while (mq.size() > 0) step(0, 0, 0, 1, 0, 2'b00, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule